// File: doc/BRIEF.md
# Command Unit Idle Interrupt Delay Timer

This block holds back the interrupt a command unit raises when it stops executing and falls idle. Each transmitted frame's command carries a 16-bit delay in timebase ticks, which the block latches. When the command unit goes idle, the status field changes at once, but the not-active bit and the interrupt line wait for a countdown of that many ticks to reach zero. A zero delay posts both on the edge of the idle event.

If software restarts or resumes the command unit before the count expires, the pending interrupt is dropped and no interrupt is raised. A new frame delay that arrives while a count is pending replaces the remaining count, so the delay rolls forward. A chain of frames issued back to back therefore produces one interrupt, after the last frame. The interrupt stays high until it is acknowledged.

Top module: `cu_idle_irq_delay`

## Requirements
- R1: With a zero effective delay, an idle event (`idle_enter_i`) sets `not_active_o` and `irq_o` in the first cycle after that edge.
- R2: With a nonzero delay D, `irq_o` and `not_active_o` rise in the cycle after the D-th `tick_i` that follows the idle event, and not earlier. Ticks seen while no count is pending have no effect.
- R3: `cu_start_i` or `cu_resume_i` cancels a pending count. No interrupt follows from that count, `not_active_o` is 0, and `cu_status_o` reads active (2'b10) from the next cycle.
- R4: An idle event sets `cu_status_o` to idle (2'b00) and pulses `status_upd_o` for one cycle in the next cycle, whatever the delay. With D>0, `not_active_o` stays 0 until the count expires. Start and resume also pulse `status_upd_o`.
- R5: A `frame_dly_vld_i` strobe latches `frame_dly_i` as the delay. If a count is pending, the strobe reloads the count with the new value, so the interrupt comes N ticks after the strobe. A reload with zero expires at once.
- R6: An idle event during a pending count restarts the count from the latched delay. A delay strobe in the same cycle as an idle event supplies the delay that event uses.
- R7: `irq_o` stays high until `irq_ack_i`. The acknowledge clears it in the next cycle unless an expiry happens in the same cycle, in which case the expiry wins.
- R8: After reset, `irq_o`, `not_active_o` and `status_upd_o` are 0 and `cu_status_o` is idle (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_dly_vld_i | input | 1 | Strobe: new per-frame delay on `frame_dly_i` |
| frame_dly_i | input | 16 | Per-frame delay, in ticks |
| idle_enter_i | input | 1 | Command unit leaves the active state |
| cu_start_i | input | 1 | Start command |
| cu_resume_i | input | 1 | Resume command |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| irq_ack_i | input | 1 | Clears the interrupt |
| status_upd_o | output | 1 | One-cycle pulse when the status field changes |
| cu_status_o | output | 2 | Command unit status: 2'b00 idle, 2'b10 active |
| not_active_o | output | 1 | Not-active bit, posted at expiry |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench sweeps delays from 0 to 6 with tick spacings of 1 to 3 cycles. An off-by-one counter would fire a tick early or late, and a design that ignored the spacing would fire on cycles instead of ticks. Start and resume are applied in the middle of a count; a design that failed to cancel would raise a stray interrupt. Rolling reloads, idle re-entry and a zero reload are covered too: a design that kept the old count would fire at the first deadline. The bench also confirms that the status pulse comes before the not-active bit and that the interrupt is held until acknowledge.

// File: rtl/cu_irq_dly_pkg.sv
package cu_irq_dly_pkg;
  typedef enum logic [1:0] {
    CU_IDLE   = 2'b00,
    CU_ACTIVE = 2'b10
  } cu_state_e;

  typedef struct packed {
    logic idle;
    logic cancel;
    logic reload;
    logic tick;
    logic ack;
  } cu_evt_t;
endpackage

// File: rtl/dly_latch.sv
module dly_latch #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [DLY_W-1:0] dly_q_o,
  output logic [DLY_W-1:0] dly_eff_o
);
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dly_q <= '0;
    else if (ld_i) dly_q <= dly_i;
  end

  // same-cycle strobe overrides the stored value
  assign dly_eff_o = ld_i ? dly_i : dly_q;
  assign dly_q_o   = dly_q;
endmodule

// File: rtl/idle_countdown.sv
module idle_countdown #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_eff_i,
  output logic             pend_o,
  output logic [DLY_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             eff_zero;

  assign eff_zero = (dly_eff_i == '0);

  always_comb begin
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (cancel_i) begin
      pend_d = 1'b0;
    end else if (arm_i) begin
      if (eff_zero) begin
        expire_o = 1'b1;
        pend_d   = 1'b0;
      end else begin
        pend_d = 1'b1;
        cnt_d  = dly_eff_i;
      end
    end else if (pend_q && reload_i) begin
      if (eff_zero) begin
        expire_o = 1'b1;
        pend_d   = 1'b0;
      end else begin
        cnt_d = dly_eff_i;
      end
    end else if (pend_q && tick_i) begin
      if (cnt_q <= ONE) begin
        expire_o = 1'b1;
        pend_d   = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/irq_post.sv
module irq_post
  import cu_irq_dly_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cu_evt_t   evt_i,
  input  logic      expire_i,
  output logic      status_upd_o,
  output cu_state_e status_o,
  output logic      not_active_o,
  output logic      irq_o
);
  logic      upd_q, na_q, na_d, irq_q, irq_d;
  cu_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (evt_i.cancel)    st_d = CU_ACTIVE;
    else if (evt_i.idle) st_d = CU_IDLE;

    na_d = na_q;
    if (evt_i.cancel)    na_d = 1'b0;
    else if (expire_i)   na_d = 1'b1;
    else if (evt_i.idle) na_d = 1'b0;

    irq_d = irq_q;
    if (expire_i)       irq_d = 1'b1;
    else if (evt_i.ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      st_q  <= CU_IDLE;
      na_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= evt_i.cancel | evt_i.idle;
      st_q  <= st_d;
      na_q  <= na_d;
      irq_q <= irq_d;
    end
  end

  assign status_upd_o = upd_q;
  assign status_o     = st_q;
  assign not_active_o = na_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/cu_idle_irq_delay.sv
module cu_idle_irq_delay
  import cu_irq_dly_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_dly_vld_i,
  input  logic [DLY_W-1:0] frame_dly_i,
  input  logic             idle_enter_i,
  input  logic             cu_start_i,
  input  logic             cu_resume_i,
  input  logic             tick_i,
  input  logic             irq_ack_i,
  output logic             status_upd_o,
  output logic [1:0]       cu_status_o,
  output logic             not_active_o,
  output logic             irq_o
);
  cu_evt_t          evt;
  logic [DLY_W-1:0] dly_q, dly_eff, cnt;
  logic             pend, expire;
  cu_state_e        st;

  assign evt.cancel = cu_start_i | cu_resume_i;
  assign evt.idle   = idle_enter_i & ~evt.cancel;
  assign evt.reload = frame_dly_vld_i;
  assign evt.tick   = tick_i;
  assign evt.ack    = irq_ack_i;

  dly_latch #(.DLY_W(DLY_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (frame_dly_vld_i),
    .dly_i     (frame_dly_i),
    .dly_q_o   (dly_q),
    .dly_eff_o (dly_eff)
  );

  idle_countdown #(.DLY_W(DLY_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (idle_enter_i),
    .cancel_i  (evt.cancel),
    .reload_i  (evt.reload),
    .tick_i    (evt.tick),
    .dly_eff_i (dly_eff),
    .pend_o    (pend),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  irq_post u_post (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .expire_i     (expire),
    .status_upd_o (status_upd_o),
    .status_o     (st),
    .not_active_o (not_active_o),
    .irq_o        (irq_o)
  );

  assign cu_status_o = st;
endmodule

// File: rtl/cu_idle_irq_delay_chk.sv
module cu_idle_irq_delay_chk #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_dly_vld_i,
  input logic             idle_enter_i,
  input logic             cu_start_i,
  input logic             cu_resume_i,
  input logic             tick_i,
  input logic             irq_ack_i,
  input logic             status_upd_o,
  input logic [1:0]       cu_status_o,
  input logic             not_active_o,
  input logic             irq_o,
  input logic [DLY_W-1:0] dly_q,
  input logic [DLY_W-1:0] cnt,
  input logic             pend
);
  logic quiet;
  assign quiet = !frame_dly_vld_i && !cu_start_i && !cu_resume_i;

  p_zero_immediate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_enter_i && quiet && dly_q == '0) |=> (irq_o && not_active_o));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && tick_i && quiet && !idle_enter_i && cnt > DLY_W'(1)) |=>
      (pend && cnt == $past(cnt) - DLY_W'(1)));

  p_cancel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_start_i || cu_resume_i) |=> (!pend && !not_active_o && cu_status_o == 2'b10));

  p_status_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_enter_i && !cu_start_i && !cu_resume_i) |=> (status_upd_o && cu_status_o == 2'b00));

  p_rise_with_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> not_active_o);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_pending_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> !not_active_o);
endmodule

bind cu_idle_irq_delay cu_idle_irq_delay_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .frame_dly_vld_i (frame_dly_vld_i),
  .idle_enter_i    (idle_enter_i),
  .cu_start_i      (cu_start_i),
  .cu_resume_i     (cu_resume_i),
  .tick_i          (tick_i),
  .irq_ack_i       (irq_ack_i),
  .status_upd_o    (status_upd_o),
  .cu_status_o     (cu_status_o),
  .not_active_o    (not_active_o),
  .irq_o           (irq_o),
  .dly_q           (dly_q),
  .cnt             (cnt),
  .pend            (pend)
);

// File: tb/cu_idle_irq_delay_bench.sv
module cu_idle_irq_delay_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 0, idle = 0, start = 0, resume = 0, tick = 0, ack = 0;
  logic [15:0] dly = '0;
  logic        upd, na, irq;
  logic [1:0]  st;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cu_idle_irq_delay u_cu_idle_irq_delay (
    .clk_i(clk), .rst_ni(rst_n), .frame_dly_vld_i(vld), .frame_dly_i(dly),
    .idle_enter_i(idle), .cu_start_i(start), .cu_resume_i(resume),
    .tick_i(tick), .irq_ack_i(ack), .status_upd_o(upd), .cu_status_o(st),
    .not_active_o(na), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs already set at a negedge; advance one cycle, then clear strobes
  task automatic step();
    @(negedge clk);
    vld = 0; idle = 0; start = 0; resume = 0; tick = 0; ack = 0;
  endtask

  task automatic load(input int d);
    vld = 1; dly = 16'(d); step();
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic go_active();
    start = 1; step();
    ack = 1; step();
  endtask

  // R1 R2 R4: delay d, tick every gap cycles
  task automatic run_delay(input int d, input int gap);
    load(d);
    idle = 1; step();
    chk("R4 status pulse", int'(upd), 1);
    chk("R4 status idle", int'(st), 0);
    chk("R1/R4 not_active at entry", int'(na), (d == 0) ? 1 : 0);
    chk("R1 irq at entry", int'(irq), (d == 0) ? 1 : 0);
    for (int k = 1; k <= d; k++) begin
      idle_cycles(gap - 1);
      chk("R2 no irq between ticks", int'(irq), 0);
      tick = 1; step();
      chk("R2 irq at tick", int'(irq), (k == d) ? 1 : 0);
      chk("R2 not_active at tick", int'(na), (k == d) ? 1 : 0);
    end
    go_active();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 irq reset", int'(irq), 0);
    chk("R8 na reset", int'(na), 0);
    chk("R8 upd reset", int'(upd), 0);
    chk("R8 status reset", int'(st), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: ticks with nothing pending change nothing
    tick = 1; step(); tick = 1; step();
    chk("R2 idle ticks no irq", int'(irq), 0);

    for (int g = 1; g <= 3; g++)
      for (int d = 0; d <= 6; d++) run_delay(d, g);

    // R3: cancel by start and by resume
    for (int m = 0; m < 2; m++) begin
      load(4);
      idle = 1; step();
      tick = 1; step(); tick = 1; step();
      if (m == 0) start = 1; else resume = 1;
      step();
      chk("R3 status active", int'(st), 2);
      chk("R4 cancel upd pulse", int'(upd), 1);
      for (int k = 0; k < 6; k++) begin tick = 1; step(); end
      chk("R3 no irq after cancel", int'(irq), 0);
      chk("R3 na clear after cancel", int'(na), 0);
    end

    // R5: rolling reload 3 -> 5
    load(3);
    idle = 1; step();
    tick = 1; step(); tick = 1; step();
    load(5);
    for (int k = 1; k <= 5; k++) begin
      tick = 1; step();
      chk("R5 rolling reload", int'(irq), (k == 5) ? 1 : 0);
    end
    go_active();

    // R5: reload with zero expires at once
    load(4);
    idle = 1; step();
    tick = 1; step();
    load(0);
    chk("R5 zero reload fires", int'(irq), 1);
    go_active();

    // R6: idle re-entry restarts from latched value
    load(4);
    idle = 1; step();
    for (int k = 0; k < 3; k++) begin tick = 1; step(); end
    idle = 1; step();
    for (int k = 1; k <= 4; k++) begin
      tick = 1; step();
      chk("R6 restart count", int'(irq), (k == 4) ? 1 : 0);
    end
    go_active();

    // R6: strobe in same cycle as idle supplies the delay
    load(7);
    vld = 1; dly = 16'd2; idle = 1; step();
    tick = 1; step();
    chk("R6 same-cycle delay early", int'(irq), 0);
    tick = 1; step();
    chk("R6 same-cycle delay", int'(irq), 1);

    // R7: hold until ack, then clear
    idle_cycles(5);
    chk("R7 irq held", int'(irq), 1);
    ack = 1; step();
    chk("R7 ack clears", int'(irq), 0);
    go_active();

    // R7: expiry beats simultaneous ack
    load(1);
    idle = 1; step();
    tick = 1; ack = 1; step();
    chk("R7 expiry wins over ack", int'(irq), 1);
    go_active();

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule